// File: doc/BRIEF.md
# Dual Receive Queue Read Port

This block holds incoming packet data in two separate quadlet queues, one for request packets and one for response packets, and lets a host drain them through a small register window. The receive side pushes 32-bit quadlets into the queue named by a select input. Each quadlet carries a tag that marks the final quadlet of its packet. The host pops one quadlet from a queue with each read of that queue's data address.

A status word tells the host, for each queue, whether a quadlet is waiting and whether the waiting quadlet closes its packet. The host uses this word to find packet boundaries without any length field. A read of an empty queue does not pop anything. It returns zero and latches a sticky error bit, which the host clears by writing a one to it. Each queue reports a full flag back to the receive side. A push into a full queue is refused.

Top module: `rxq_read_port`

## Requirements
- R1: After reset both queues are empty. The status word reads 0, `host_rdata_o` is 0 and `rx_full_o` is 0.
- R2: A cycle with `rx_valid_i` high pushes `rx_data_i` into the queue that `rx_sel_i` selects (0 = request, 1 = response). The push is tagged with `rx_last_i`.
- R3: A read at address 0 (request) or address 1 (response) of a non-empty queue pops its head quadlet. The quadlet appears on `host_rdata_o` in the cycle after the read and stays there until the next read. Each queue keeps first-in first-out order.
- R4: A read at address 2 returns the status word. Bit 0 is request-quadlet-available and bit 2 is response-quadlet-available. Both are derived every cycle from the queue being non-empty.
- R5: Status bit 1 (request) and bit 3 (response) are 1 exactly when the queue is non-empty and its head quadlet is tagged as the final quadlet of its packet.
- R6: A data read of an empty queue returns 0 and leaves that queue unchanged. It also sets the sticky error bit, which is status bit 4.
- R7: A write to address 2 with write-data bit 4 at 1 clears the error bit. The same write with bit 4 at 0 leaves the error bit unchanged.
- R8: Each queue holds 16 quadlets. `rx_full_o[q]` is 1 while queue q holds 16. A push into a full queue is dropped, and the stored quadlets stay unchanged.
- R9: A push and a pop on the same queue in the same cycle both take effect.
- R10: A push to one queue and a read of the other queue are independent of each other.
- R11: Host writes to addresses 0, 1 and 3 have no effect. A read of address 3 returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Push strobe from the receiver |
| rx_sel_i | input | 1 | Target queue: 0 request, 1 response |
| rx_data_i | input | 32 | Quadlet to push |
| rx_last_i | input | 1 | Pushed quadlet ends its packet |
| rx_full_o | output | 2 | Per-queue full flag (bit 0 request, bit 1 response) |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_addr_i | input | 2 | Register address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data, valid the cycle after a read |

## Verification
Two things can fall in the same cycle: a receiver push and a host pop on the same queue. The bench provokes this once with a queue holding one quadlet and once with an empty queue. In the first case it judges that the old head comes out and that the new quadlet stays behind as the only entry. In the second case it judges that the read returns zero and raises the error, and that the pushed quadlet still lands and is read back afterwards.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned QW      = 32;
  localparam int unsigned NQ      = 2;
  localparam int unsigned SELW    = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int unsigned HAW     = 2;
  localparam int unsigned ADDR_ST = 2;
  localparam int unsigned ST_ERR  = 2 * NQ;

  typedef struct packed {
    logic          last;
    logic [QW-1:0] data;
  } rxq_entry_t;

  function automatic int unsigned avail_bit(int unsigned q);
    return 2 * q;
  endfunction

  function automatic int unsigned last_bit(int unsigned q);
    return 2 * q + 1;
  endfunction
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  rxq_entry_t push_entry_i,
  input  logic       pop_i,
  output rxq_entry_t head_o,
  output logic       empty_o,
  output logic       full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rxq_entry_t      mem [DEPTH];
  logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]   count_q;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign head_o  = mem[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= push_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R8: gating upstream must never push into a full queue
  a_r8_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6: gating upstream must never pop an empty queue
  a_r6_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r9_push_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(count_q));
  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> count_q == $past(count_q) + 1'b1);
  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/rxq_host_regs.sv
module rxq_host_regs
  import rxq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [HAW-1:0]  addr_i,
  input  logic [QW-1:0]   wdata_i,
  input  logic [NQ-1:0]   q_empty_i,
  input  rxq_entry_t      q_head_i [NQ],
  output logic [NQ-1:0]   pop_o,
  output logic            err_o,
  output logic [QW-1:0]   rdata_o
);
  logic [NQ-1:0] rd_hit;
  logic [QW-1:0] stat_word;
  logic [QW-1:0] rdata_d;
  logic          rd_err;
  logic          wr_clr;

  for (genvar q = 0; q < NQ; q++) begin : g_dec
    assign rd_hit[q] = rd_i && (addr_i == HAW'(q));
    assign pop_o[q]  = rd_hit[q] && !q_empty_i[q];
  end

  always_comb begin
    stat_word = '0;
    for (int unsigned q = 0; q < NQ; q++) begin
      stat_word[avail_bit(q)] = !q_empty_i[q];
      stat_word[last_bit(q)]  = !q_empty_i[q] && q_head_i[q].last;
    end
    stat_word[ST_ERR] = err_o;
  end

  always_comb begin
    rdata_d = '0;
    for (int unsigned q = 0; q < NQ; q++) begin
      if (pop_o[q]) rdata_d = q_head_i[q].data;
    end
    if (addr_i == HAW'(ADDR_ST)) rdata_d = stat_word;
  end

  assign rd_err = |(rd_hit & q_empty_i);
  assign wr_clr = wr_i && !rd_i && (addr_i == HAW'(ADDR_ST)) && wdata_i[ST_ERR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd_i)        rdata_o <= rdata_d;
      if (rd_err)      err_o   <= 1'b1;
      else if (wr_clr) err_o   <= 1'b0;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    a_r6_err_on_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_hit[q] && q_empty_i[q]) |=> err_o);
    a_r6_zero_on_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_hit[q] && q_empty_i[q]) |=> rdata_o == '0);
  end
  a_r7_clear_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == HAW'(ADDR_ST) && wdata_i[ST_ERR]) |=> !err_o);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !wr_i) |=> err_o);
  a_r3_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/rxq_read_port.sv
module rxq_read_port
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_valid_i,
  input  logic [SELW-1:0]    rx_sel_i,
  input  logic [QW-1:0]      rx_data_i,
  input  logic               rx_last_i,
  output logic [NQ-1:0]      rx_full_o,
  input  logic               host_rd_i,
  input  logic               host_wr_i,
  input  logic [HAW-1:0]     host_addr_i,
  input  logic [QW-1:0]      host_wdata_i,
  output logic [QW-1:0]      host_rdata_o
);
  rxq_entry_t    in_entry;
  rxq_entry_t    head [NQ];
  logic [NQ-1:0] push, pop, empty;
  logic          err;

  assign in_entry = '{last: rx_last_i, data: rx_data_i};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign push[q] = rx_valid_i && (rx_sel_i == SELW'(q)) && !rx_full_o[q];

    rxq_fifo #(.DEPTH(DEPTH)) i_fifo (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_i       (push[q]),
      .push_entry_i (in_entry),
      .pop_i        (pop[q]),
      .head_o       (head[q]),
      .empty_o      (empty[q]),
      .full_o       (rx_full_o[q])
    );
  end

  rxq_host_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (host_rd_i),
    .wr_i      (host_wr_i),
    .addr_i    (host_addr_i),
    .wdata_i   (host_wdata_i),
    .q_empty_i (empty),
    .q_head_i  (head),
    .pop_o     (pop),
    .err_o     (err),
    .rdata_o   (host_rdata_o)
  );

  // R10: a push into one queue never disturbs the other queue's state
  a_r10_onehot_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push));
  a_r3_onehot_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop));
  a_r6_err_rises_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err) |-> $past(host_rd_i));
endmodule

// File: tb/test_rxq_read_port.sv
`timescale 1ns/1ps
module test_rxq_read_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [0:0]  rx_sel = '0;
  logic [31:0] rx_data = '0;
  logic        rx_last = 1'b0;
  logic [1:0]  rx_full;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rxq_read_port i_rxq_read_port (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_sel_i(rx_sel), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_full_o(rx_full),
    .host_rd_i(host_rd), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input bit q, input logic [31:0] d, input bit last);
    rx_valid = 1'b1; rx_sel = q; rx_data = d; rx_last = last;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic clr_err();
    wr(2'd2, 32'h10);
  endtask

  task automatic t_reset();
    check(rx_full === 2'b00, "R1 full", {30'd0, rx_full}, 32'd0);
    check(host_rdata === 32'd0, "R1 rdata", host_rdata, 32'd0);
    expect_rd(2'd2, 32'd0, "R1 status");
  endtask

  task automatic t_req_order();
    push(1'b0, 32'hA000_0001, 1'b0);
    push(1'b0, 32'hA000_0002, 1'b1);
    expect_rd(2'd2, 32'h01, "R4 req avail");
    expect_rd(2'd0, 32'hA000_0001, "R3 req head");
    expect_rd(2'd2, 32'h03, "R5 req last");
    expect_rd(2'd0, 32'hA000_0002, "R3 req second");
    expect_rd(2'd2, 32'h00, "R4 req drained");
  endtask

  task automatic t_rsp_and_isolation();
    push(1'b1, 32'hB000_0001, 1'b1);
    push(1'b0, 32'hC000_0001, 1'b0);
    expect_rd(2'd2, 32'h0D, "R10 both queues");
    expect_rd(2'd1, 32'hB000_0001, "R2 rsp data");
    expect_rd(2'd2, 32'h01, "R10 req kept");
    expect_rd(2'd0, 32'hC000_0001, "R10 req data");
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    host_rd = 1'b1; host_addr = 2'd0;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
    check(d === 32'd0, "R6 empty read zero", d, 32'd0);
    expect_rd(2'd2, 32'h10, "R6 err set");
    push(1'b0, 32'hD000_0001, 1'b1);
    wr(2'd2, 32'h0);
    expect_rd(2'd2, 32'h13, "R7 write 0 keeps err");
    clr_err();
    expect_rd(2'd2, 32'h03, "R7 cleared");
    expect_rd(2'd0, 32'hD000_0001, "R6 queue untouched");
    expect_rd(2'd1, 32'd0, "R6 rsp empty read");
    expect_rd(2'd2, 32'h10, "R6 rsp err set");
    clr_err();
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) push(1'b0, 32'h100 + i, i == 15);
    check(rx_full === 2'b01, "R8 full flag", {30'd0, rx_full}, 32'd1);
    push(1'b0, 32'hDEAD_BEEF, 1'b0);
    for (int i = 0; i < 16; i++) expect_rd(2'd0, 32'h100 + i, "R8 content kept");
    check(rx_full === 2'b00, "R8 full drops", {30'd0, rx_full}, 32'd0);
    expect_rd(2'd2, 32'h00, "R8 dropped push");
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    push(1'b1, 32'hE000_0001, 1'b0);
    rx_valid = 1'b1; rx_sel = 1'b1; rx_data = 32'hE000_0002; rx_last = 1'b1;
    host_rd = 1'b1; host_addr = 2'd1;
    @(negedge clk);
    rx_valid = 1'b0; host_rd = 1'b0; rx_last = 1'b0;
    d = host_rdata;
    check(d === 32'hE000_0001, "R9 pop old head", d, 32'hE000_0001);
    expect_rd(2'd2, 32'h0C, "R9 new entry only");
    expect_rd(2'd1, 32'hE000_0002, "R9 pushed data");
    rx_valid = 1'b1; rx_sel = 1'b0; rx_data = 32'hF000_0001;
    host_rd = 1'b1; host_addr = 2'd0;
    @(negedge clk);
    rx_valid = 1'b0; host_rd = 1'b0;
    d = host_rdata;
    check(d === 32'd0, "R9 empty pop with push", d, 32'd0);
    expect_rd(2'd2, 32'h11, "R9 err and push landed");
    expect_rd(2'd0, 32'hF000_0001, "R9 pushed req");
    clr_err();
  endtask

  task automatic t_ignored();
    push(1'b0, 32'h7777_0001, 1'b0);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    expect_rd(2'd3, 32'd0, "R11 addr 3 zero");
    expect_rd(2'd2, 32'h01, "R11 status unchanged");
    expect_rd(2'd0, 32'h7777_0001, "R11 data unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_req_order();
    t_rsp_and_isolation();
    t_empty_read();
    t_full();
    t_same_cycle();
    t_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule